// File: doc/BRIEF.md
# Segment Identifier Scrambler

This block turns an effective address into a scrambled 36-bit virtual segment identifier. It first forms a 36-bit proto identifier. In kernel mode the proto is the segment number, which is the address shifted right by 28 so that each segment spans 256 MB. In user mode the proto is a 19-bit context placed above the low 16 bits of the segment number, with bit 35 left at zero. It then multiplies the proto by the prime 200730139 and reduces the product modulo 2^36−1. The reduction uses no divider. The upper and lower parts of the product are added together, and an end-around carry correction follows. Because the multiplier is coprime to the modulus, the mapping is one-to-one.

Requests arrive with a valid/ready pair. The datapath is a two-stage pipeline that accepts one request every cycle. A small controller runs it through three states:
- OFF: held in reset, not ready.
- IDLE: ready, and stage 1 is empty.
- BUSY: ready, and stage 1 holds a request.

The transitions are OFF→IDLE on the first edge after reset is released, IDLE→BUSY on an accepted request, BUSY→BUSY on an accepted request, and BUSY→IDLE when no request is accepted.

An error flag travels with every result. It marks a proto that is reserved: either all ones, or one whose top two bits are 10.

Top module: `vsid_scrambler`

## Requirements
- R1: In kernel mode (`req_kernel`=1) the proto identifier is `req_ea[63:28]`.
- R2: In user mode the proto identifier is {1'b0, `req_ctx[18:0]`, `req_ea[43:28]`}. Address bits 63..44 have no effect on the result.
- R3: `rsp_vsid` equals (proto × 200730139) mod (2^36−1).
- R4: A request accepted at a rising edge gives `rsp_valid`=1 with its result after the second rising edge that follows. Requests on consecutive cycles produce results on consecutive cycles, in order.
- R5: `rsp_err`=1 exactly when the proto is 36'hF_FFFF_FFFF or proto[35:34] is 2'b10. A user-mode proto never raises it.
- R6: A proto of all ones gives `rsp_vsid`=0. A valid result never equals 2^36−1.
- R7: While `rst_n` is low, `req_ready`=0 and `rsp_valid`=0. `req_ready` rises after the first rising edge with `rst_n` high.
- R8: A cycle without an accepted request, including a `req_valid` that is raised while in reset, leaves `rsp_valid`=0 two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_kernel | input | 1 | 1 = kernel proto, 0 = user proto |
| req_ctx | input | 19 | User context number |
| req_ea | input | 64 | Effective address |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_vsid | output | 36 | Scrambled segment identifier |
| rsp_err | output | 1 | Proto was reserved |

## Verification
The multiply of a new request and the fold of the previous request happen in the same cycle whenever requests arrive back to back. This is when the controller stays in BUSY. The bench streams its whole vector table without gaps, so every cycle accepts one proto while folding another. It judges each result two cycles after that vector was driven, against a modulo computed independently. Kernel, user, reserved and boundary protos are mixed, so a result that crosses over between stages, or an error flag that gets out of step with its result, shows up as a mismatch.

// File: rtl/vsid_pkg.sv
package vsid_pkg;
    localparam int EA_W       = 64;
    localparam int VSID_W     = 36;
    localparam int SEG_SHIFT  = 28;
    localparam int CTX_W      = 19;
    localparam int USEG_W     = 16;
    localparam int MULT_W     = 28;
    localparam logic [MULT_W-1:0] SCRAMBLE_MULT = 28'd200730139;
    localparam int PROD_W     = VSID_W + MULT_W;
    localparam int UPROTO_W   = CTX_W + USEG_W;

    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_IDLE = 2'd1,
        PS_BUSY = 2'd2
    } pipe_state_e;
endpackage

// File: rtl/vsid_proto_build.sv
module vsid_proto_build
    import vsid_pkg::*;
(
    input  logic              kernel,
    input  logic [CTX_W-1:0]  ctx,
    input  logic [EA_W-1:0]   ea,
    output logic [VSID_W-1:0] proto,
    output logic              reserved
);
    logic [VSID_W-1:0] seg_num;
    logic [VSID_W-1:0] user_proto;
    logic              unused_low_ea;

    assign seg_num       = ea[SEG_SHIFT +: VSID_W];
    assign unused_low_ea = ^ea[SEG_SHIFT-1:0];

    generate
        if (UPROTO_W < VSID_W) begin : g_pad
            assign user_proto = {{(VSID_W-UPROTO_W){1'b0}}, ctx, seg_num[USEG_W-1:0]};
        end else begin : g_nopad
            assign user_proto = {ctx, seg_num[USEG_W-1:0]};
        end
    endgenerate

    always_comb begin
        proto    = kernel ? seg_num : user_proto;
        reserved = (&proto) || (proto[VSID_W-1 -: 2] == 2'b10);
    end
endmodule

// File: rtl/vsid_mult_stage.sv
module vsid_mult_stage
    import vsid_pkg::*;
(
    input  logic              clk,
    input  logic              load,
    input  logic [VSID_W-1:0] proto,
    input  logic              reserved,
    output logic [PROD_W-1:0] product,
    output logic              err
);
    always_ff @(posedge clk) begin
        if (load) begin
            product <= PROD_W'(proto) * PROD_W'(SCRAMBLE_MULT);
            err     <= reserved;
        end
    end
endmodule

// File: rtl/vsid_fold_stage.sv
module vsid_fold_stage
    import vsid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PROD_W-1:0] product,
    input  logic              in_err,
    output logic              out_valid,
    output logic [VSID_W-1:0] out_vsid,
    output logic              out_err
);
    logic [VSID_W:0] folded;
    logic [VSID_W:0] folded_inc;
    logic [VSID_W:0] corrected;

    always_comb begin
        folded     = {1'b0, product[VSID_W-1:0]}
                   + {{(VSID_W+1-MULT_W){1'b0}}, product[PROD_W-1:VSID_W]};
        folded_inc = folded + 1'b1;
        corrected  = folded + {{VSID_W{1'b0}}, folded_inc[VSID_W]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            out_vsid <= corrected[VSID_W-1:0];
            out_err  <= in_err;
        end
    end
endmodule

// File: rtl/vsid_scrambler.sv
module vsid_scrambler
    import vsid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_kernel,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [EA_W-1:0]   req_ea,
    output logic              rsp_valid,
    output logic [VSID_W-1:0] rsp_vsid,
    output logic              rsp_err
);
    pipe_state_e       state_q, state_d;
    logic              accept;
    logic              s1_full;
    logic [VSID_W-1:0] proto;
    logic              proto_bad;
    logic [PROD_W-1:0] s1_product;
    logic              s1_err;

    assign accept = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_OFF:  state_d = PS_IDLE;
            PS_IDLE: state_d = accept ? PS_BUSY : PS_IDLE;
            PS_BUSY: state_d = accept ? PS_BUSY : PS_IDLE;
            default: state_d = PS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = (state_q != PS_OFF);
        s1_full   = (state_q == PS_BUSY);
    end

    vsid_proto_build u_proto (
        .kernel   (req_kernel),
        .ctx      (req_ctx),
        .ea       (req_ea),
        .proto    (proto),
        .reserved (proto_bad)
    );

    vsid_mult_stage u_mult (
        .clk      (clk),
        .load     (accept),
        .proto    (proto),
        .reserved (proto_bad),
        .product  (s1_product),
        .err      (s1_err)
    );

    vsid_fold_stage u_fold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s1_full),
        .product   (s1_product),
        .in_err    (s1_err),
        .out_valid (rsp_valid),
        .out_vsid  (rsp_vsid),
        .out_err   (rsp_err)
    );
endmodule

// File: rtl/vsid_scrambler_chk.sv
module vsid_scrambler_chk
    import vsid_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_kernel,
    input logic [EA_W-1:0]   req_ea,
    input logic              rsp_valid,
    input logic [VSID_W-1:0] rsp_vsid,
    input logic              rsp_err
);
    // R4: accepted request yields a result two edges later
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 rsp_valid);

    // R8: no accepted request, no result
    p_no_phantom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |-> ##2 !rsp_valid);

    // R6: reserved identifier never appears on a valid result
    p_no_reserved_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_vsid != '1));

    // R5 / R6: all-ones kernel proto flags and folds to zero
    p_allones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kernel && (&req_ea[EA_W-1:SEG_SHIFT]))
        |-> ##2 (rsp_err && rsp_vsid == '0));

    // R5: user protos are never flagged
    p_user_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_kernel) |-> ##2 !rsp_err);

    // R7: ready once out of reset for more than one edge
    p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> req_ready);
endmodule

bind vsid_scrambler vsid_scrambler_chk u_chk (.*);

// File: tb/test_vsid_scrambler.sv
module test_vsid_scrambler;
    typedef struct packed {
        logic        kern;
        logic [18:0] ctx;
        logic [63:0] ea;
        logic        err;
    } tv_t;

    localparam int NV = 8;
    localparam tv_t TV [NV] = '{
        '{1'b1, 19'd0,       64'hC000_0000_0000_0000, 1'b0},
        '{1'b1, 19'd0,       64'hFFFF_FFFF_F000_0000, 1'b1},
        '{1'b1, 19'd5,       64'h8000_0000_1000_0000, 1'b1},
        '{1'b1, 19'd0,       64'h0000_0000_1000_0000, 1'b0},
        '{1'b0, 19'h7FFFF,   64'h0000_0FFF_FFFF_FFFF, 1'b0},
        '{1'b0, 19'h12345,   64'hFFFF_F123_4000_0000, 1'b0},
        '{1'b1, 19'd0,       64'h4000_0000_0000_0000, 1'b0},
        '{1'b1, 19'h7FFFF,   64'h0000_0000_0FFF_FFFF, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_kernel = 1'b0;
    logic [18:0] req_ctx = '0;
    logic [63:0] req_ea = '0;
    logic        rsp_valid;
    logic [35:0] rsp_vsid;
    logic        rsp_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vsid_scrambler i_vsid_scrambler (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_kernel (req_kernel),
        .req_ctx    (req_ctx),
        .req_ea     (req_ea),
        .rsp_valid  (rsp_valid),
        .rsp_vsid   (rsp_vsid),
        .rsp_err    (rsp_err)
    );

    function automatic logic [35:0] exp_proto(input logic k, input logic [18:0] c,
                                              input logic [63:0] a);
        if (k) return a[63:28];
        return {1'b0, c, a[43:28]};
    endfunction

    function automatic logic [35:0] exp_vsid(input logic [35:0] p);
        logic [63:0] prod;
        logic [63:0] r;
        prod = {28'd0, p} * 64'd200730139;
        r = prod % 64'h0000_000F_FFFF_FFFF;
        return r[35:0];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input tv_t v, input logic vld);
        req_valid  = vld;
        req_kernel = v.kern;
        req_ctx    = v.ctx;
        req_ea     = v.ea;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(20 * 5000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R7: reset state
        repeat (3) @(negedge clk);
        check("R7 ready in reset", {63'd0, req_ready}, 64'd0);
        check("R7 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 ready after release", {63'd0, req_ready}, 64'd1);

        // Back-to-back stream: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2) begin
                tv_t v;
                logic [35:0] p;
                v = TV[i-2];
                p = exp_proto(v.kern, v.ctx, v.ea);
                check(v.kern ? "R4 valid (R1 kernel)" : "R4 valid (R2 user)",
                      {63'd0, rsp_valid}, 64'd1);
                check(v.kern ? "R3 vsid R1" : "R3 vsid R2", {28'd0, rsp_vsid}, {28'd0, exp_vsid(p)});
                check("R5 err flag", {63'd0, rsp_err}, {63'd0, v.err});
                if (&p) check("R6 all-ones proto gives zero", {28'd0, rsp_vsid}, 64'd0);
            end
            if (i < NV) drive(TV[i], 1'b1);
            else        drive(TV[0], 1'b0);
            @(negedge clk);
        end
        check("R8 no result after idle", {63'd0, rsp_valid}, 64'd0);

        // Single request after a gap: R3 R4
        drive(TV[3], 1'b1);
        @(negedge clk);
        drive(TV[3], 1'b0);
        check("R4 not yet valid after one edge", {63'd0, rsp_valid}, 64'd0);
        @(negedge clk);
        check("R4 valid after two edges", {63'd0, rsp_valid}, 64'd1);
        check("R3 proto one gives multiplier", {28'd0, rsp_vsid}, 64'd200730139);
        @(negedge clk);
        check("R8 single pulse", {63'd0, rsp_valid}, 64'd0);

        // Request raised during reset is ignored: R7 R8
        rst_n = 1'b0;
        drive(TV[0], 1'b1);
        repeat (3) @(negedge clk);
        check("R7 ready low under reset", {63'd0, req_ready}, 64'd0);
        check("R8 no result from reset request", {63'd0, rsp_valid}, 64'd0);
        drive(TV[0], 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 no late result after reset", {63'd0, rsp_valid}, 64'd0);
        check("R7 ready again", {63'd0, req_ready}, 64'd1);

        finish_run();
    end
endmodule